// File: doc/BRIEF.md
# Dual-Queue Converter Interrupt Requester

This block raises interrupts on behalf of a converter that runs two command queues. Each queue reports two kinds of event as single-cycle strobes. A completion strobe comes when the result of the queue's final command word is written. A pause strobe comes when the result of a command word carrying a pause mark is written. The block latches the four events as sticky flags and gates each flag with its own enable bit. Each queue has a 3-bit priority level, and the block uses it to drive a registered request level towards the bus master.

When the bus master runs an acknowledge cycle, it presents the level it is servicing. If that level belongs to a queue that has a pending enabled source, the block answers on the next cycle with a one-cycle response strobe and a vector. The vector is a programmable base with a 2-bit source index in its low bits, so each of the four sources is serviced through its own vector. Software reaches the flags, enables, levels and vector base through a simple registered read/write port.

Top module: `dq_irq_requester`

## Requirements
- R1: After synchronous reset, all flags, enables, levels and the vector base are zero, and `irq_level`, `ack_resp`, `ack_vector` and `rd_data` are zero.
- R2: A strobe on `evt_done[q]` sets the completion flag of queue q. In the flag word, bit 0 is queue-1 completion, bit 1 is queue-1 pause, bit 2 is queue-2 completion and bit 3 is queue-2 pause.
- R3: A strobe on `evt_pause[q]` sets the pause flag of queue q, at the bit positions given in R2.
- R4: A write of the flag word (`wr_sel`=0) clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A set strobe in the same cycle as a clear leaves that flag set.
- R5: A source is pending only when its flag and its enable are both 1. The enable word (`wr_sel`=1) uses the bit positions of R2.
- R6: The level word (`wr_sel`=2) holds the queue-1 level in bits 2:0 and the queue-2 level in bits 5:3. A level of 0 stops both sources of that queue from being pending.
- R7: `irq_level` equals the level of the highest-ranked pending source, or 0 when none is pending. The ranking is queue-1 completion, then queue-1 pause, then queue-2 completion, then queue-2 pause. `irq_level` follows a change of flags, enables or levels one clock later.
- R8: When `iack_valid` is high and `iack_level` equals the level of a queue with a pending source, then one clock later `ack_resp` is high for that cycle. `ack_vector` then holds the base in bits VEC_W-1:2 and, in bits 1:0, the index of the highest-ranked pending source at that level (0 to 3 in the ranking of R7).
- R9: An acknowledge whose level is 0, or whose level matches no queue with a pending source, produces no response and leaves `ack_vector` unchanged.
- R10: When both queues hold the same level, an acknowledge at that level returns the highest-ranked pending source across both queues.
- R11: `rd_data` shows, one clock after `rd_sel` is applied, the word that `rd_sel` selects, zero-extended. The selections are 0 for flags, 1 for enables, 2 for levels and 3 for the base. The base sits in bits VEC_W-1:2, matching `wr_data` on a base write (`wr_sel`=3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_done | input | 2 | Completion strobes, bit 0 for queue 1, bit 1 for queue 2 |
| evt_pause | input | 2 | Pause strobes, bit 0 for queue 1, bit 1 for queue 2 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for writing |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Register selected for reading |
| rd_data | output | DATA_W | Registered read data |
| iack_valid | input | 1 | Acknowledge cycle in progress |
| iack_level | input | LVL_W | Level being acknowledged |
| irq_level | output | LVL_W | Registered request level, 0 when idle |
| ack_resp | output | 1 | One-cycle response to a matching acknowledge |
| ack_vector | output | VEC_W | Base plus source index |

## Verification
The bench builds the block with its defaults: 3-bit levels, an 8-bit data word and an 8-bit vector, which leaves a 6-bit base. With these values all seven nonzero levels can be programmed, so the two queues can be set above each other, below each other and equal. That makes it possible to show that the internal ranking, not the numeric level, decides `irq_level`. The 6-bit base fills the data word, so a wrong field position in the vector or in the read-back shows up at once.

// File: rtl/dq_irq_pkg.sv
package dq_irq_pkg;
  localparam int NSRC = 4;
  localparam int NQUEUE = 2;

  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_EN   = 2'd1,
    SEL_LVL  = 2'd2,
    SEL_BASE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dq_irq_flags.sv
module dq_irq_flags #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flag_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) flag_o[i] <= 1'b0;
      else     flag_o[i] <= (flag_o[i] & ~clr_i[i]) | set_i[i];
    end

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flag_o[i]);
  end
endmodule

// File: rtl/dq_irq_arbiter.sv
module dq_irq_arbiter #(
  parameter int NSRC  = 4,
  parameter int LVL_W = 3
) (
  input  logic [NSRC-1:0]  flag_i,
  input  logic [NSRC-1:0]  en_i,
  input  logic [LVL_W-1:0] lvl_q1_i,
  input  logic [LVL_W-1:0] lvl_q2_i,
  input  logic [LVL_W-1:0] ack_lvl_i,
  output logic [LVL_W-1:0] req_lvl_o,
  output logic             hit_o,
  output logic [1:0]       hit_idx_o
);
  logic [LVL_W-1:0] src_lvl;

  // Walk from lowest rank up; later (higher-ranked) sources overwrite.
  always_comb begin
    req_lvl_o = '0;
    hit_o     = 1'b0;
    hit_idx_o = 2'd0;
    src_lvl   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      src_lvl = (i < 2) ? lvl_q1_i : lvl_q2_i;
      if (flag_i[i] && en_i[i] && (src_lvl != '0)) begin
        req_lvl_o = src_lvl;
        if (src_lvl == ack_lvl_i) begin
          hit_o     = 1'b1;
          hit_idx_o = 2'(i);
        end
      end
    end
  end
endmodule

// File: rtl/dq_irq_requester.sv
module dq_irq_requester
  import dq_irq_pkg::*;
#(
  parameter int LVL_W  = 3,
  parameter int DATA_W = 8,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        evt_done,
  input  logic [1:0]        evt_pause,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              iack_valid,
  input  logic [LVL_W-1:0]  iack_level,
  output logic [LVL_W-1:0]  irq_level,
  output logic              ack_resp,
  output logic [VEC_W-1:0]  ack_vector
);
  localparam int BASE_W = VEC_W - 2;

  logic [NSRC-1:0]   flags, en_q, set_v, clr_v;
  logic [LVL_W-1:0]  lvl_q1, lvl_q2, req_lvl, ack_lvl_eff;
  logic [BASE_W-1:0] base_q;
  logic              hit;
  logic [1:0]        hit_idx;
  reg_sel_e          wsel, rsel;

  assign wsel  = reg_sel_e'(wr_sel);
  assign rsel  = reg_sel_e'(rd_sel);
  assign set_v = {evt_pause[1], evt_done[1], evt_pause[0], evt_done[0]};
  assign clr_v = (wr_en && wsel == SEL_FLAG) ? wr_data[NSRC-1:0] : '0;
  assign ack_lvl_eff = iack_valid ? iack_level : '0;

  dq_irq_flags #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v), .flag_o(flags)
  );

  dq_irq_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W)) u_arb (
    .flag_i(flags), .en_i(en_q), .lvl_q1_i(lvl_q1), .lvl_q2_i(lvl_q2),
    .ack_lvl_i(ack_lvl_eff), .req_lvl_o(req_lvl), .hit_o(hit),
    .hit_idx_o(hit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      lvl_q1 <= '0;
      lvl_q2 <= '0;
      base_q <= '0;
    end else if (wr_en) begin
      case (wsel)
        SEL_EN:   en_q   <= wr_data[NSRC-1:0];
        SEL_LVL:  begin
          lvl_q1 <= wr_data[LVL_W-1:0];
          lvl_q2 <= wr_data[2*LVL_W-1:LVL_W];
        end
        SEL_BASE: base_q <= wr_data[VEC_W-1:2];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level  <= '0;
      ack_resp   <= 1'b0;
      ack_vector <= '0;
      rd_data    <= '0;
    end else begin
      irq_level <= req_lvl;
      ack_resp  <= hit;
      if (hit) ack_vector <= {base_q, hit_idx};
      case (rsel)
        SEL_FLAG: rd_data <= DATA_W'(flags);
        SEL_EN:   rd_data <= DATA_W'(en_q);
        SEL_LVL:  rd_data <= DATA_W'({lvl_q2, lvl_q1});
        default:  rd_data <= DATA_W'({base_q, 2'b00});
      endcase
    end
  end

  // R8
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    ack_resp |-> $past(iack_valid));

  // R9
  ack_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    ack_resp |-> ($past(iack_level) != '0));

  // R6
  lvl_owned_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_level != '0) |-> (irq_level == $past(lvl_q1) || irq_level == $past(lvl_q2)));

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flags & en_q) == '0) |-> (irq_level == '0));
endmodule

// File: tb/dq_irq_requester_bench.sv
module dq_irq_requester_bench;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] evt_done = '0, evt_pause = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [7:0] wr_data = '0;
  logic       iack_valid = 1'b0;
  logic [2:0] iack_level = '0;
  logic [7:0] rd_data;
  logic [2:0] irq_level;
  logic       ack_resp;
  logic [7:0] ack_vector;

  dq_irq_requester u_dq_irq_requester (
    .clk(clk), .rst(rst), .evt_done(evt_done), .evt_pause(evt_pause),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .iack_valid(iack_valid), .iack_level(iack_level),
    .irq_level(irq_level), .ack_resp(ack_resp), .ack_vector(ack_vector)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0, cmp_on = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_fl, m_en, m_l1, m_l2, m_base;
  int e_irq, e_ack, e_vec, e_rd;
  int best, hit, lv, clr, setv;

  always @(posedge clk) begin
    if (rst) begin
      m_fl = 0; m_en = 0; m_l1 = 0; m_l2 = 0; m_base = 0;
      e_irq = 0; e_ack = 0; e_vec = 0; e_rd = 0;
    end else begin
      best = -1; hit = -1;
      for (int i = 0; i < 4; i++) begin
        lv = (i < 2) ? m_l1 : m_l2;
        if (((m_fl >> i) & 1) == 1 && ((m_en >> i) & 1) == 1 && lv != 0) begin
          if (best < 0) best = i;
          if (hit < 0 && iack_valid && lv == int'(iack_level)) hit = i;
        end
      end
      e_irq = (best < 0) ? 0 : ((best < 2) ? m_l1 : m_l2);
      e_ack = (hit >= 0) ? 1 : 0;
      if (hit >= 0) e_vec = m_base * 4 + hit;
      case (rd_sel)
        2'd0: e_rd = m_fl;
        2'd1: e_rd = m_en;
        2'd2: e_rd = m_l1 + m_l2 * 8;
        default: e_rd = m_base * 4;
      endcase
      clr = (wr_en && wr_sel == 2'd0) ? int'(wr_data) & 15 : 0;
      setv = int'(evt_done[0]) + 2 * int'(evt_pause[0]) + 4 * int'(evt_done[1]) + 8 * int'(evt_pause[1]);
      m_fl = ((m_fl & ~clr) | setv) & 15;
      if (wr_en) begin
        case (wr_sel)
          2'd1: m_en = int'(wr_data) & 15;
          2'd2: begin m_l1 = int'(wr_data) & 7; m_l2 = (int'(wr_data) >> 3) & 7; end
          2'd3: m_base = (int'(wr_data) >> 2) & 63;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R7 irq_level model", int'(irq_level), e_irq);
      chk("R8 ack_resp model", int'(ack_resp), e_ack);
      chk("R8 ack_vector model", int'(ack_vector), e_vec);
      chk("R11 rd_data model", int'(rd_data), e_rd);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output int v);
    rd_sel = sel;
    tick(1);
    v = int'(rd_data);
  endtask

  task automatic ack(input logic [2:0] l);
    iack_valid = 1'b1; iack_level = l;
    tick(1);
    iack_valid = 1'b0; iack_level = '0;
  endtask

  initial begin
    int v;
    tick(3);
    rst = 1'b0;
    cmp_on = 1;
    // R1: reset state
    chk("R1 irq_level", int'(irq_level), 0);
    chk("R1 ack_resp", int'(ack_resp), 0);
    rd(2'd0, v); chk("R1 flags", v, 0);

    wr(2'd2, 8'h2B);          // q1 level 3, q2 level 5
    wr(2'd1, 8'h0F);
    wr(2'd3, 8'hA0);          // base 0x28
    rd(2'd3, v); chk("R11 base readback", v, 8'hA0);
    rd(2'd2, v); chk("R6 level readback", v, 8'h2B);

    // R3: queue-2 pause
    evt_pause = 2'b10; tick(1); evt_pause = '0; tick(1);
    chk("R3 irq from q2 pause", int'(irq_level), 5);
    rd(2'd0, v); chk("R3 flag bit 3", v, 8);

    // R2 + R7: queue-1 completion outranks despite lower level
    evt_done = 2'b01; tick(1); evt_done = '0; tick(1);
    chk("R7 rank beats level", int'(irq_level), 3);
    rd(2'd0, v); chk("R2 flag bit 0", v, 9);

    // R8: acknowledges
    ack(3'd5); chk("R8 ack q2 resp", int'(ack_resp), 1); chk("R8 ack q2 vec", int'(ack_vector), 8'hA3);
    tick(1); chk("R8 single cycle", int'(ack_resp), 0);
    ack(3'd3); chk("R8 ack q1 vec", int'(ack_vector), 8'hA0);
    // R9: non-matching and zero levels
    ack(3'd4); chk("R9 no resp lvl4", int'(ack_resp), 0); chk("R9 vec held", int'(ack_vector), 8'hA0);
    ack(3'd0); chk("R9 no resp lvl0", int'(ack_resp), 0);

    // R4: set wins over clear, then clear alone
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h01; evt_done = 2'b01;
    tick(1); wr_en = 1'b0; wr_data = '0; evt_done = '0;
    rd(2'd0, v); chk("R4 set wins", v, 9);
    wr(2'd0, 8'h01);
    rd(2'd0, v); chk("R4 w1c clears", v, 8);
    chk("R4 irq falls back", int'(irq_level), 5);

    // R5: disable queue-2 pause
    wr(2'd1, 8'h07); tick(1);
    chk("R5 enable gates", int'(irq_level), 0);
    rd(2'd0, v); chk("R5 flag kept", v, 8);

    // R6: level 0 disables queue
    wr(2'd1, 8'h0F);
    wr(2'd2, 8'h03); tick(1);
    chk("R6 zero level off", int'(irq_level), 0);
    ack(3'd5); chk("R6 no ack", int'(ack_resp), 0);

    // R10: shared level 6, q1 pause and q2 completion pending
    wr(2'd2, 8'h36);
    evt_pause = 2'b01; evt_done = 2'b10; tick(1); evt_pause = '0; evt_done = '0; tick(1);
    chk("R10 irq level", int'(irq_level), 6);
    ack(3'd6); chk("R10 resp", int'(ack_resp), 1); chk("R10 vec idx1", int'(ack_vector), 8'hA1);
    wr(2'd0, 8'h02); tick(1);
    ack(3'd6); chk("R10 next source", int'(ack_vector), 8'hA2);

    tick(4);
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 20000);
    if (!done_flag) begin
      done_flag = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule